// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is an 8-bit synchronous serial transceiver attached to a small CPU register interface. The CPU writes a byte into a transmit buffer. When the shift register is free, the byte moves into it and is shifted out on `txd_o`, least-significant bit first. At the same time the receive shift register collects one bit from `rxd_i` per shift clock. When the eighth bit arrives, the received byte moves into a receive buffer. Transmit and receive always use the same shift clock.

The shift clock comes from one of two sources. It can be generated on chip: the system clock, optionally divided by four, is divided again by a reload counter programmed with `n`, which gives a serial clock of 1/(2(n+1)) or 1/(8(n+1)) of the system clock. It can also come from an external master on `sclk_i`. In external mode the block pulls `rdy_no` low to tell the master that a byte is waiting.

Status flags report buffer and shifter state. Two single-cycle interrupt pulses signal transmit and receive events, and the source of the transmit pulse can be selected. If the CPU refills the buffer before the current byte finishes, the next byte follows with no idle clock periods.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register reads 0x03 (transmit-empty and shift-complete set, receive-full and overrun clear). The control register reads 0x00, `sclk_o`, `txd_o` and `rdy_no` are high, and both interrupt outputs are low.
- R2: Register map at `reg_addr_i`:
  - 0 is data: a write fills the transmit buffer and a read returns the receive buffer.
  - 1 is status: bit0 transmit-empty, bit1 shift-complete, bit2 receive-full, bit3 overrun.
  - 2 is control: bit0 external clock, bit1 divide-by-4 prescale, bit2 transmit-interrupt source, bit3 overrun clear (write-only, reads 0), bit6 synchronous enable.
  - 3 is the divider value `n`.
  - Control and divider read back what was written.
- R3: No transfer starts while control bit6 is 0. A byte written in that state waits in the buffer with status 0x02, and it is sent once bit6 is set.
- R4: With the internal clock, `sclk_o` idles high. Each half period lasts (n+1) system clocks, or 4(n+1) with the prescale bit set, so a full period is 2(n+1) or 8(n+1) cycles.
- R5: Data is shifted LSB first. `txd_o` changes on the falling shift-clock edge and `rxd_i` is sampled on the rising edge.
- R6: Loading the shift register sets transmit-empty and clears shift-complete. Shift-complete sets again after the eighth bit if no byte is waiting. If a byte is waiting, it follows with the same clock spacing and no gap.
- R7: The eighth received bit moves the byte into the receive buffer, sets receive-full and pulses `rx_irq_o`. A data read clears receive-full.
- R8: The transmit interrupt pulses on the transmit-empty 0-to-1 transition when control bit2 is 0, and on the shift-complete 0-to-1 transition when bit2 is 1.
- R9: A byte that completes while receive-full is set sets overrun and replaces the buffered byte. Overrun clears on a control write with bit3 set, or on a data read that follows a status read showing overrun. A data read alone does not clear it.
- R10: With control bit0 set, the shift clock comes from `sclk_i`. `rdy_no` goes low when a byte is loaded and returns high on the first falling edge of `sclk_i`, and `sclk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on data/status) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock, idles high |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data, idles high |
| rdy_no | output | 1 | Ready-to-transfer flag for an external master, active low |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The bench measures the spacing of shift-clock rising edges across a byte boundary. A design that inserted an idle period while reloading from the buffer would show a longer interval between bit 7 and bit 8. It runs both transmit-interrupt sources, where a swapped selection would make the pulse appear at the load instead of at completion. It also reads data without a preceding status read during an overrun, where a design that cleared the flag on every data read would lose the error. Finally, it writes a byte while the port is disabled and drives an external clock while checking `rdy_no`, which catches a port that starts too early or releases ready at the wrong edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_DIV  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_EXT  = 0;
  localparam int unsigned CTL_PRE  = 1;
  localparam int unsigned CTL_SRC  = 2;
  localparam int unsigned CTL_ECLR = 3;
  localparam int unsigned CTL_EN   = 6;

  typedef struct packed {
    logic ovr;
    logic rbf;
    logic tsc;
    logic tbe;
  } stat_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             sclk_q;
  logic             pre_tick;
  logic             tick;

  assign pre_tick = !pre_en_i || (pre_cnt == PW'(PRE_DIV - 1));
  assign tick     = pre_tick && (div_cnt == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      sclk_q  <= 1'b1;
    end else if (!run_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      sclk_q  <= 1'b1;
    end else begin
      if (pre_en_i) pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick)     sclk_q  <= ~sclk_q;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = run_i && tick && sclk_q;
  assign rise_o = run_i && tick && !sclk_q;
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-1:0], sig_i};
  end

  assign fall_o =  sync_q[STAGES] && !sync_q[STAGES-1];
  assign rise_o = !sync_q[STAGES] &&  sync_q[STAGES-1];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic          idle_i,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          done_o,
  output logic [DW-1:0] rx_byte_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [CW-1:0] bit_cnt;
  logic          txd_q;

  assign done_o    = rise_i && (bit_cnt == CW'(DW - 1));
  assign rx_byte_o = {rxd_i, rx_sh[DW-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      txd_q   <= 1'b1;
    end else begin
      if (fall_i) begin
        txd_q <= tx_sh[0];
        tx_sh <= {1'b0, tx_sh[DW-1:1]};
      end else if (idle_i) begin
        txd_q <= 1'b1;
      end
      if (rise_i) begin
        rx_sh   <= rx_byte_o;
        bit_cnt <= bit_cnt + 1'b1;
      end
      // reload after the last rise so chained bytes start at bit 0
      if (load_i) begin
        tx_sh   <= load_data_i;
        bit_cnt <= '0;
      end
    end
  end

  assign txd_o = txd_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned PRE_DIV     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          sclk_i,
  output logic          sclk_o,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          rdy_no,
  output logic          tx_irq_o,
  output logic          rx_irq_o
);
  logic          en_q, ext_q, pre_q, src_q;
  logic [DW-1:0] div_q, tx_buf, rx_buf;
  logic          tbe_q, tsc_q, rbf_q, ovr_q, arm_q, rdy_q;
  logic          tbe_d, tsc_d, rbf_d, ovr_d;
  stat_t         stat;

  logic wr_data, wr_ctrl, wr_div, rd_data, rd_stat, eclr;
  logic active, run_int, load, start, chain, done, idle;
  logic ifall, irise, sfall, srise, fall, rise;
  logic [DW-1:0] rx_byte;

  assign wr_data = reg_wr_i && (reg_addr_i == REG_DATA);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign wr_div  = reg_wr_i && (reg_addr_i == REG_DIV);
  assign rd_data = reg_rd_i && (reg_addr_i == REG_DATA);
  assign rd_stat = reg_rd_i && (reg_addr_i == REG_STAT);
  assign eclr    = wr_ctrl && reg_wdata_i[CTL_ECLR];

  assign active  = en_q && !tsc_q;
  assign run_int = active && !ext_q;
  assign idle    = tsc_q || !en_q;

  ssp_clkgen #(.DIV_W(DW), .PRE_DIV(PRE_DIV)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_int),
    .pre_en_i (pre_q),
    .div_i    (div_q),
    .sclk_o   (sclk_o),
    .fall_o   (ifall),
    .rise_o   (irise)
  );

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_i),
    .fall_o (sfall),
    .rise_o (srise)
  );

  assign fall = ext_q ? (active && sfall) : ifall;
  assign rise = ext_q ? (active && srise) : irise;

  assign start = en_q && tsc_q && !tbe_q;
  assign chain = done && !tbe_q;
  assign load  = start || chain;

  ssp_shifter #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_buf),
    .fall_i      (fall),
    .rise_i      (rise),
    .idle_i      (idle),
    .rxd_i       (rxd_i),
    .txd_o       (txd_o),
    .done_o      (done),
    .rx_byte_o   (rx_byte)
  );

  always_comb begin
    tbe_d = tbe_q;
    if (load)    tbe_d = 1'b1;
    if (wr_data) tbe_d = 1'b0;
    tsc_d = tsc_q;
    if (load)      tsc_d = 1'b0;
    else if (done) tsc_d = 1'b1;
    rbf_d = rbf_q;
    if (rd_data) rbf_d = 1'b0;
    if (done)    rbf_d = 1'b1;
    ovr_d = ovr_q;
    if (eclr || (rd_data && arm_q))    ovr_d = 1'b0;
    if (done && rbf_q && !rd_data)     ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ext_q <= 1'b0; pre_q <= 1'b0; src_q <= 1'b0;
      div_q <= '0; tx_buf <= '0; rx_buf <= '0;
      tbe_q <= 1'b1; tsc_q <= 1'b1; rbf_q <= 1'b0; ovr_q <= 1'b0;
      arm_q <= 1'b0; rdy_q <= 1'b1;
      tx_irq_o <= 1'b0; rx_irq_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[CTL_EN];
        ext_q <= reg_wdata_i[CTL_EXT];
        pre_q <= reg_wdata_i[CTL_PRE];
        src_q <= reg_wdata_i[CTL_SRC];
      end
      if (wr_div)  div_q  <= reg_wdata_i;
      if (wr_data) tx_buf <= reg_wdata_i;
      if (done)    rx_buf <= rx_byte;
      tbe_q <= tbe_d;
      tsc_q <= tsc_d;
      rbf_q <= rbf_d;
      ovr_q <= ovr_d;
      // status-then-data clear sequence
      if (rd_data)                arm_q <= 1'b0;
      else if (rd_stat && ovr_q)  arm_q <= 1'b1;
      if (!ext_q)              rdy_q <= 1'b1;
      else if (load)           rdy_q <= 1'b0;
      else if (active && sfall) rdy_q <= 1'b1;
      tx_irq_o <= src_q ? (tsc_d && !tsc_q) : (tbe_d && !tbe_q);
      rx_irq_o <= done;
    end
  end

  assign rdy_no = rdy_q;
  assign stat   = '{ovr: ovr_q, rbf: rbf_q, tsc: tsc_q, tbe: tbe_q};

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_DATA: reg_rdata_o = rx_buf;
      REG_STAT: reg_rdata_o[3:0] = stat;
      REG_CTRL: begin
        reg_rdata_o[CTL_EN]  = en_q;
        reg_rdata_o[CTL_EXT] = ext_q;
        reg_rdata_o[CTL_PRE] = pre_q;
        reg_rdata_o[CTL_SRC] = src_q;
      end
      default:  reg_rdata_o = div_q;
    endcase
  end
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic rdy_no,
  input logic tx_irq_o,
  input logic rx_irq_o,
  input logic tbe_q,
  input logic tsc_q,
  input logic rbf_q,
  input logic ovr_q,
  input logic src_q
);
  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsc_q |-> sclk_o);
  // R6
  load_from_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tsc_q) |-> $past(!tbe_q));
  // R7
  rx_irq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rbf_q);
  // R8
  tx_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> ($past(src_q) ? tsc_q : tbe_q));
  // R9
  ovr_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rbf_q));
  // R10
  rdy_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |-> !tsc_q);
endmodule

bind sync_serial_port ssp_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_o   (sclk_o),
  .rdy_no   (rdy_no),
  .tx_irq_o (tx_irq_o),
  .rx_irq_o (rx_irq_o),
  .tbe_q    (tbe_q),
  .tsc_q    (tsc_q),
  .rbf_q    (rbf_q),
  .ovr_q    (ovr_q),
  .src_q    (src_q)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_EXT   = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk_ext = 1'b1;
  logic       ext_tb = 1'b0;
  logic       rxd = 1'b1;
  logic       sclk_o, txd_o, rdy_no, tx_irq_o, rx_irq_o;

  sync_serial_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_i(sclk_ext), .sclk_o(sclk_o), .rxd_i(rxd), .txd_o(txd_o),
    .rdy_no(rdy_no), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial-side monitor: drives rxd on falls, captures txd on rises
  logic [7:0] rx_src [0:255];
  logic [7:0] tx_cap [0:255];
  int         rise_t [0:1023];
  int   byte_idx = 0, bit_idx = 0, rise_n = 0, txirq_n = 0, rxirq_n = 0;
  logic prev_s = 1'b1;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    logic s;
    s = ext_tb ? sclk_ext : sclk_o;
    if (prev_s && !s) rxd <= rx_src[byte_idx][bit_idx];
    if (!prev_s && s) begin
      cap = {txd_o, cap[7:1]};
      rise_t[rise_n] = cyc;
      rise_n++;
      bit_idx++;
      if (bit_idx == 8) begin
        tx_cap[byte_idx] = cap;
        byte_idx++;
        bit_idx = 0;
      end
    end
    prev_s = s;
    if (tx_irq_o) txirq_n++;
    if (rx_irq_o) rxirq_n++;
  end

  function automatic int exp_period(int n, bit pre);
    return 2 * (n + 1) * (pre ? 4 : 1);
  endfunction

  function automatic logic [7:0] exp_stat(bit tbe, bit tsc, bit rbf, bit ovr);
    return {4'b0, ovr, rbf, tsc, tbe};
  endfunction

  function automatic logic [7:0] mk_ctrl(bit en, bit ext, bit pre, bit src);
    return {1'b0, en, 3'b0, src, pre, ext};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_bytes(int target);
    while (byte_idx < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_clocks(int nbits);
    for (int i = 0; i < nbits; i++) begin
      sclk_ext = 1'b0; repeat (HALF_EXT) @(negedge clk);
      sclk_ext = 1'b1; repeat (HALF_EXT) @(negedge clk);
    end
  endtask

  // one internal-clock byte; optionally read back the received byte
  task automatic xfer(string req, logic [7:0] tx, logic [7:0] rx, bit do_read);
    int b;
    logic [7:0] d;
    b = byte_idx;
    rx_src[b] = rx;
    reg_wr(2'd0, tx);
    wait_bytes(b + 1);
    chk(req, tx_cap[b], tx);
    if (do_read) begin
      reg_rd(2'd0, d);
      chk(req, d, rx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int b, rb, ti, ri, n;
    bit pre;
    logic [7:0] ta, tb2, ra, rb2;
    void'($urandom(32'h1bad5eed));
    for (int i = 0; i < 256; i++) rx_src[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    reg_rd(2'd1, d); chk("R1 status", d, exp_stat(1, 1, 0, 0));
    reg_rd(2'd2, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 sclk", sclk_o, 1'b1);
    chk("R1 txd", txd_o, 1'b1);
    chk("R1 rdy", rdy_no, 1'b1);
    chk("R1 irq", {tx_irq_o, rx_irq_o}, 2'b00);

    // R2 register readback, overrun-clear bit reads 0
    reg_wr(2'd3, 8'hA5);
    reg_rd(2'd3, d); chk("R2 div", d, 8'hA5);
    reg_wr(2'd2, 8'h4E);
    reg_rd(2'd2, d); chk("R2 ctrl", d, 8'h46);

    // R3 disabled port holds the byte
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd3, 8'h00);
    rb = rise_n; b = byte_idx;
    rx_src[b] = 8'h5A;
    reg_wr(2'd0, 8'h3C);
    repeat (100) @(negedge clk);
    chk("R3 no clock", rise_n, rb);
    reg_rd(2'd1, d); chk("R3 status", d, exp_stat(0, 1, 0, 0));
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 0));
    wait_bytes(b + 1);
    chk("R3 tx", tx_cap[b], 8'h3C);
    reg_rd(2'd0, d); chk("R3 rx", d, 8'h5A);

    // R5 LSB first, R7 receive flags
    ri = rxirq_n;
    xfer("R5 lsb", 8'h81, 8'h01, 1'b0);
    reg_rd(2'd1, d); chk("R7 full", d, exp_stat(1, 1, 1, 0));
    chk("R7 rx irq", rxirq_n - ri, 1);
    reg_rd(2'd0, d); chk("R5 rx lsb", d, 8'h01);
    reg_rd(2'd1, d); chk("R7 read clears", d, exp_stat(1, 1, 0, 0));

    // R4 divider and prescale
    reg_wr(2'd3, 8'd3);
    reg_wr(2'd2, mk_ctrl(1, 0, 1, 0));
    rb = rise_n;
    xfer("R4 data", 8'hE7, 8'h18, 1'b1);
    chk("R4 period", rise_t[rb + 1] - rise_t[rb], exp_period(3, 1));
    chk("R4 span", rise_t[rb + 7] - rise_t[rb], 7 * exp_period(3, 1));
    chk("R4 idle high", sclk_o, 1'b1);

    // R8 transmit interrupt source
    reg_wr(2'd3, 8'd0);
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 0));
    ti = txirq_n; b = byte_idx;
    reg_wr(2'd0, 8'h11);
    repeat (3) @(negedge clk);
    chk("R8 empty src at load", txirq_n - ti, 1);
    wait_bytes(b + 1);
    chk("R8 empty src total", txirq_n - ti, 1);
    reg_rd(2'd0, d);
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 1));
    ti = txirq_n; b = byte_idx;
    reg_wr(2'd0, 8'h22);
    repeat (3) @(negedge clk);
    chk("R8 done src at load", txirq_n - ti, 0);
    wait_bytes(b + 1);
    chk("R8 done src total", txirq_n - ti, 1);
    reg_rd(2'd0, d);

    // R6 back-to-back, also R9 overrun with status-then-data clear
    reg_wr(2'd3, 8'd1);
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 0));
    ti = txirq_n; rb = rise_n; b = byte_idx;
    rx_src[b] = 8'hC3; rx_src[b + 1] = 8'h96;
    reg_wr(2'd0, 8'hA1);
    d = 8'h00;
    while (!d[0]) reg_rd(2'd1, d);
    chk("R6 shifting", d[1], 1'b0);
    reg_wr(2'd0, 8'h4B);
    wait_bytes(b + 2);
    chk("R6 byte0", tx_cap[b], 8'hA1);
    chk("R6 byte1", tx_cap[b + 1], 8'h4B);
    chk("R6 no gap", rise_t[rb + 8] - rise_t[rb + 7], exp_period(1, 0));
    chk("R6 two loads", txirq_n - ti, 2);
    reg_rd(2'd1, d); chk("R9 overrun", d, exp_stat(1, 1, 1, 1));
    reg_rd(2'd0, d); chk("R9 newest kept", d, 8'h96);
    reg_rd(2'd1, d); chk("R9 seq clear", d, exp_stat(1, 1, 0, 0));

    // R9 data read alone keeps overrun; control bit clears it
    xfer("R9 a", 8'h01, 8'h10, 1'b0);
    xfer("R9 b", 8'h02, 8'h20, 1'b0);
    reg_rd(2'd0, d); chk("R9 data", d, 8'h20);
    reg_rd(2'd1, d); chk("R9 lone read", d, exp_stat(1, 1, 0, 1));
    reg_rd(2'd0, d);
    reg_rd(2'd1, d); chk("R9 cleared", d, exp_stat(1, 1, 0, 0));
    xfer("R9 c", 8'h03, 8'h30, 1'b0);
    xfer("R9 d", 8'h04, 8'h40, 1'b0);
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 0) | 8'h08);
    reg_rd(2'd1, d); chk("R9 ctrl clear", d, exp_stat(1, 1, 1, 0));
    reg_rd(2'd0, d); chk("R9 ctrl data", d, 8'h40);

    // R10 external clock and ready
    ext_tb = 1'b1;
    reg_wr(2'd2, mk_ctrl(1, 1, 0, 0));
    b = byte_idx;
    rx_src[b] = 8'h6D;
    reg_wr(2'd0, 8'hC6);
    repeat (3) @(negedge clk);
    chk("R10 ready low", rdy_no, 1'b0);
    sclk_ext = 1'b0; repeat (HALF_EXT) @(negedge clk);
    chk("R10 ready released", rdy_no, 1'b1);
    chk("R10 sclk_o idle", sclk_o, 1'b1);
    sclk_ext = 1'b1; repeat (HALF_EXT) @(negedge clk);
    ext_clocks(7);
    repeat (4) @(negedge clk);
    chk("R10 tx", tx_cap[b], 8'hC6);
    reg_rd(2'd1, d); chk("R10 status", d, exp_stat(1, 1, 1, 0));
    reg_rd(2'd0, d); chk("R10 rx", d, 8'h6D);
    ext_tb = 1'b0;

    // R4 R5 random settings and data
    for (int k = 0; k < 8; k++) begin
      n = $urandom_range(0, 4);
      pre = 1'($urandom % 2);
      ta = 8'($urandom); ra = 8'($urandom);
      reg_wr(2'd3, 8'(n));
      reg_wr(2'd2, mk_ctrl(1, 0, pre, 0));
      rb = rise_n;
      xfer("R5 random", ta, ra, 1'b1);
      chk("R4 random period", rise_t[rb + 4] - rise_t[rb + 3], exp_period(n, pre));
    end

    // R6 random back-to-back pair
    tb2 = 8'($urandom); rb2 = 8'($urandom); ta = 8'($urandom); ra = 8'($urandom);
    reg_wr(2'd3, 8'd2);
    reg_wr(2'd2, mk_ctrl(1, 0, 0, 0));
    rb = rise_n; b = byte_idx;
    rx_src[b] = ra; rx_src[b + 1] = rb2;
    reg_wr(2'd0, ta);
    d = 8'h00;
    while (!d[0]) reg_rd(2'd1, d);
    reg_wr(2'd0, tb2);
    wait_bytes(b + 2);
    chk("R6 rand pair", {tx_cap[b], tx_cap[b + 1]}, {ta, tb2});
    chk("R6 rand no gap", rise_t[rb + 8] - rise_t[rb + 7], exp_period(2, 0));
    reg_rd(2'd1, d);
    reg_rd(2'd0, d); chk("R9 rand newest", d, rb2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule